// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt line of a real-time clock. A one-cycle timebase enable arrives at the crystal rate. The block divides it into a sub-second phase and emits the strobe that advances the external seconds counter. A three-bit mode register selects what the active-low interrupt line does. It can be released, held low, or run as a free 2 Hz or 1 Hz square wave locked to the seconds phase. It can also act as a latched level interrupt that fires on every second, every minute, every hour or every month.

In the square-wave modes, the falling edge of the 1 Hz wave comes a fixed number of timebase ticks before the seconds strobe. The status flag mirrors the line. In the level modes, the line falls in the same cycle as the seconds strobe. It stays low, with the flag set, until software clears the flag. The minute, hour and month boundaries are reported by the external calendar counters as carry levels. A write to the seconds counter restarts the sub-second phase.

Top module: `rtc_pirq_gen`

## Requirements
- R1: While reset is asserted, irq_n is 1, flag is 0 and sec_inc is 0. The mode register resets to 010 (2 Hz square wave).
- R2: In mode 000, irq_n is 1 and flag is 0. In mode 001, irq_n is 0 and flag is 0. In neither mode does any input set the flag.
- R3: Let c be the sub-second count, 0 to N-1, where N = 2**DIV_LOG2 timebase ticks. In mode 010, irq_n is 0 exactly when (c mod N/2) < N/4. In mode 011, irq_n is 0 exactly when c < N/2. In both modes, flag equals the inverse of irq_n. Both outputs reflect the count as it stands after the clock edge.
- R4: sec_inc is a one-clock strobe. It is raised once every N ticks, at the edge where c reaches LAG_TICKS, which is LAG_TICKS ticks after a 1 Hz falling edge. This holds in every mode and for any spacing of the ticks.
- R5: After reset or after a seconds write, the first sec_inc comes N+LAG_TICKS ticks later.
- R6: sec_wr sets c to 0 at that edge, overriding a tick in the same cycle. In the square-wave modes, irq_n is therefore low in the next cycle.
- R7: In mode 100, flag goes to 1 and irq_n goes to 0 in the same cycle that sec_inc is high.
- R8: Modes 101, 110 and 111 use min_carry, hour_carry and month_carry respectively. In each, the flag is set only if the selected carry is high at the edge that raises sec_inc. A carry at any other time is ignored.
- R9: In level modes, flag stays 1 and irq_n stays 0 until flag_clr. After flag_clr, both are released in the next cycle. If an event and a clear fall on the same edge, the event wins.
- R10: In modes 010 and 011, flag_clr has no effect on flag or irq_n.
- R11: A mode write whose value differs from the current mode clears a set level flag, and the new mode drives the outputs from the next cycle. A write of the current value changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase enable |
| sec_wr | input | 1 | Seconds counter written; restarts sub-second phase |
| mode_we | input | 1 | Mode register write strobe |
| mode_wd | input | 3 | Mode value to write |
| flag_clr | input | 1 | Software write of 0 to the status flag |
| min_carry | input | 1 | Next second increment enters a new minute |
| hour_carry | input | 1 | Next second increment enters a new hour |
| month_carry | input | 1 | Next second increment enters a new month |
| sec_inc | output | 1 | Strobe advancing the external seconds counter |
| irq_n | output | 1 | Registered active-low interrupt line |
| flag | output | 1 | Interrupt status flag |

## Verification
The hardest case to reach is a clear landing on the very edge that sets a level flag. The seconds-strobe gating that follows a seconds write is nearly as hard. The bench keeps a tick-by-tick model of the sub-second phase, which lets it predict the edge of the next increment. It walks the timebase up to that edge before it places the clear, the carry or the mode write. It also issues seconds writes in mid-phase, together with a tick, and then counts out the full N+LAG_TICKS delay before the next strobe.

// File: rtl/rtc_pirq_pkg.sv
`timescale 1ns/1ps
package rtc_pirq_pkg;

   // Encoding is behavioural: bit 2 marks the level family and
   // bits 1:0 pick the carry source within it.
   typedef enum logic [2:0] {
      M_OFF    = 3'b000,
      M_LOW    = 3'b001,
      M_P2HZ   = 3'b010,
      M_P1HZ   = 3'b011,
      M_LSEC   = 3'b100,
      M_LMIN   = 3'b101,
      M_LHOUR  = 3'b110,
      M_LMONTH = 3'b111
   } pirq_mode_e;

   localparam pirq_mode_e MODE_RESET = M_P2HZ;

endpackage

// File: rtl/rtc_pirq_presc.sv
`timescale 1ns/1ps
module rtc_pirq_presc #(
   parameter int unsigned DIV_LOG2  = 15,
   parameter int unsigned LAG_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sec_wr,
   output logic wave1_low_d,
   output logic wave2_low_d,
   output logic sec_hit,
   output logic sec_inc
);
   localparam int unsigned PW = DIV_LOG2;
   localparam logic [PW-1:0] CNT_TOP = '1;

   if (DIV_LOG2 < 3) begin : g_bad_div
      $error("rtc_pirq_presc: DIV_LOG2 must be at least 3");
   end
   if (LAG_TICKS >= (1 << (DIV_LOG2 - 1))) begin : g_bad_lag
      $error("rtc_pirq_presc: LAG_TICKS must be below half a second");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] cnt_d;

   always_comb begin
      if (sec_wr)    cnt_d = '0;
      else if (tick) cnt_d = cnt_q + 1'b1;
      else           cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // Square-wave phases of the count as it will stand after this edge.
   assign wave1_low_d = ~cnt_d[PW-1];
   assign wave2_low_d = ~cnt_d[PW-2];

   if (LAG_TICKS == 0) begin : g_nolag
      // The increment coincides with the falling edge at wrap.
      assign sec_hit = tick & ~sec_wr & (cnt_q == CNT_TOP);
   end else begin : g_lag
      localparam logic [PW-1:0] LAG_M1 = PW'(LAG_TICKS - 1);
      logic armed_q;

      // Armed only once a full wrap has passed since phase zero.
      always_ff @(posedge clk) begin
         if (!rst_n)                           armed_q <= 1'b0;
         else if (sec_wr)                      armed_q <= 1'b0;
         else if (tick && (cnt_q == CNT_TOP))  armed_q <= 1'b1;
      end

      assign sec_hit = tick & ~sec_wr & armed_q & (cnt_q == LAG_M1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sec_inc <= 1'b0;
      else        sec_inc <= sec_hit;
   end

endmodule

// File: rtl/rtc_pirq_modereg.sv
`timescale 1ns/1ps
module rtc_pirq_modereg
   import rtc_pirq_pkg::*;
#(
   parameter pirq_mode_e RST_MODE = MODE_RESET
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_we,
   input  logic [2:0] mode_wd,
   output pirq_mode_e mode_q,
   output pirq_mode_e mode_d
);
   assign mode_d = mode_we ? pirq_mode_e'(mode_wd) : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= RST_MODE;
      else        mode_q <= mode_d;
   end

endmodule

// File: rtl/rtc_pirq_evsel.sv
`timescale 1ns/1ps
module rtc_pirq_evsel
   import rtc_pirq_pkg::*;
(
   input  pirq_mode_e mode_d,
   input  logic       sec_hit,
   input  logic       min_carry,
   input  logic       hour_carry,
   input  logic       month_carry,
   output logic       lvl_ev
);
   logic [3:0] carry_vec;

   // Index follows the low mode bits: second, minute, hour, month.
   assign carry_vec = {month_carry, hour_carry, min_carry, 1'b1};
   assign lvl_ev    = sec_hit & mode_d[2] & carry_vec[mode_d[1:0]];

endmodule

// File: rtl/rtc_pirq_outreg.sv
`timescale 1ns/1ps
module rtc_pirq_outreg
   import rtc_pirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pirq_mode_e mode_q,
   input  pirq_mode_e mode_d,
   input  logic       flag_clr,
   input  logic       wave1_low_d,
   input  logic       wave2_low_d,
   input  logic       lvl_ev,
   output logic       irq_n,
   output logic       flag
);
   logic stat_q;
   logic stat_d;
   logic irq_d;
   logic mode_chg;

   assign mode_chg = (mode_d != mode_q);

   always_comb begin
      unique case (mode_d)
         M_OFF, M_LOW: stat_d = 1'b0;
         M_P2HZ:       stat_d = wave2_low_d;
         M_P1HZ:       stat_d = wave1_low_d;
         default:      stat_d = (mode_chg ? 1'b0 : (stat_q & ~flag_clr)) | lvl_ev;
      endcase
      if (mode_d == M_OFF)      irq_d = 1'b1;
      else if (mode_d == M_LOW) irq_d = 1'b0;
      else                      irq_d = ~stat_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         irq_n  <= 1'b1;
      end else begin
         stat_q <= stat_d;
         irq_n  <= irq_d;
      end
   end

   assign flag = stat_q;

endmodule

// File: rtl/rtc_pirq_gen.sv
`timescale 1ns/1ps
module rtc_pirq_gen
   import rtc_pirq_pkg::*;
#(
   parameter int unsigned DIV_LOG2  = 15,
   parameter int unsigned LAG_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       sec_wr,
   input  logic       mode_we,
   input  logic [2:0] mode_wd,
   input  logic       flag_clr,
   input  logic       min_carry,
   input  logic       hour_carry,
   input  logic       month_carry,
   output logic       sec_inc,
   output logic       irq_n,
   output logic       flag
);
   pirq_mode_e cur_mode;
   pirq_mode_e nxt_mode;
   logic       w1_low;
   logic       w2_low;
   logic       sec_hit;
   logic       lvl_ev;

   rtc_pirq_presc #(
      .DIV_LOG2  (DIV_LOG2),
      .LAG_TICKS (LAG_TICKS)
   ) u_presc (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .sec_wr      (sec_wr),
      .wave1_low_d (w1_low),
      .wave2_low_d (w2_low),
      .sec_hit     (sec_hit),
      .sec_inc     (sec_inc)
   );

   rtc_pirq_modereg #(
      .RST_MODE (MODE_RESET)
   ) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_we (mode_we),
      .mode_wd (mode_wd),
      .mode_q  (cur_mode),
      .mode_d  (nxt_mode)
   );

   rtc_pirq_evsel u_evsel (
      .mode_d      (nxt_mode),
      .sec_hit     (sec_hit),
      .min_carry   (min_carry),
      .hour_carry  (hour_carry),
      .month_carry (month_carry),
      .lvl_ev      (lvl_ev)
   );

   rtc_pirq_outreg u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_q      (cur_mode),
      .mode_d      (nxt_mode),
      .flag_clr    (flag_clr),
      .wave1_low_d (w1_low),
      .wave2_low_d (w2_low),
      .lvl_ev      (lvl_ev),
      .irq_n       (irq_n),
      .flag        (flag)
   );

endmodule

// File: rtl/rtc_pirq_chk.sv
`timescale 1ns/1ps
module rtc_pirq_chk
   import rtc_pirq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input pirq_mode_e mode_q,
   input logic       mode_we,
   input logic       flag_clr,
   input logic       sec_inc,
   input logic       irq_n,
   input logic       flag
);
   p_sec_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_inc |=> !sec_inc);

   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_OFF) |-> (irq_n && !flag));

   p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_LOW) |-> (!irq_n && !flag));

   p_flag_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2] || mode_q[1]) |-> (flag == !irq_n));

   p_sec_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_inc && (mode_q == M_LSEC)) |-> flag);

   p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2] && flag && !flag_clr && !mode_we) |=> flag);

endmodule

bind rtc_pirq_gen rtc_pirq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_q   (cur_mode),
   .mode_we  (mode_we),
   .flag_clr (flag_clr),
   .sec_inc  (sec_inc),
   .irq_n    (irq_n),
   .flag     (flag)
);

// File: tb/rtc_pirq_gen_tb.sv
`timescale 1ns/1ps
module rtc_pirq_gen_tb;
   localparam int CLK_P = 10;
   localparam int DLOG  = 4;
   localparam int N     = 1 << DLOG;
   localparam int LAG   = 3;

   logic clk = 1'b0;
   logic rst_n, tick, sec_wr, mode_we, flag_clr, min_c, hour_c, mon_c;
   logic [2:0] mode_wd;
   logic sec_inc, irq_n, flag;

   always #(CLK_P/2) clk = ~clk;

   rtc_pirq_gen #(.DIV_LOG2(DLOG), .LAG_TICKS(LAG)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sec_wr(sec_wr),
      .mode_we(mode_we), .mode_wd(mode_wd), .flag_clr(flag_clr),
      .min_carry(min_c), .hour_carry(hour_c), .month_carry(mon_c),
      .sec_inc(sec_inc), .irq_n(irq_n), .flag(flag)
   );

   typedef struct {
      int         at;
      logic [2:0] v;   // {irq_n, flag, sec_inc}
      string      tag;
   } exp_t;

   exp_t q[$];
   int   cyc   = 0;
   int   n_chk = 0;
   int   n_err = 0;

   // reference state derived from the requirements
   int         b_ph;
   logic [2:0] b_mode;
   logic       b_flag;

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s cycle %0d: irq_n/flag/sec_inc = %b, expected %b", tag, cyc, got, exp);
      end
   endtask

   // monitor: pops expected items as the design produces them
   always @(posedge clk) begin : mon
      exp_t e;
      cyc = cyc + 1;
      #(CLK_P/4);
      while (q.size() > 0 && q[0].at <= cyc) begin
         e = q.pop_front();
         if (e.at < cyc) begin
            n_chk++;
            n_err++;
            $display("FAIL %s: sample for cycle %0d missed, got %b expected %b", e.tag, e.at, 3'bxxx, e.v);
         end else begin
            check(e.tag, {irq_n, flag, sec_inc}, e.v);
         end
      end
   end

   function automatic bit will_sec();
      return ((b_ph + 1) >= N + LAG) && (((b_ph + 1) % N) == LAG);
   endfunction

   // driver: applies one cycle of inputs and pushes the expected result
   task automatic step(input logic tk, input logic swr, input logic we, input logic [2:0] wd,
                       input logic clr, input logic mc, input logic hc, input logic oc,
                       input string tag);
      logic chg, secev, ev, irqv, flg;
      int   sub;
      tick = tk; sec_wr = swr; mode_we = we; mode_wd = wd;
      flag_clr = clr; min_c = mc; hour_c = hc; mon_c = oc;
      chg = we && (wd != b_mode);
      if (we) b_mode = wd;
      secev = 1'b0;
      ev    = 1'b0;
      if (swr) b_ph = 0;
      else if (tk) begin
         b_ph++;
         secev = (b_ph >= N + LAG) && ((b_ph % N) == LAG);
      end
      sub = b_ph % N;
      case (b_mode)
         3'd0: begin irqv = 1'b1; flg = 1'b0; end
         3'd1: begin irqv = 1'b0; flg = 1'b0; end
         3'd2: begin flg = ((sub % (N/2)) < (N/4)); irqv = !flg; end
         3'd3: begin flg = (sub < (N/2)); irqv = !flg; end
         default: begin
            ev = secev && ((b_mode == 3'd4) || (b_mode == 3'd5 && mc) ||
                           (b_mode == 3'd6 && hc) || (b_mode == 3'd7 && oc));
            flg  = (chg ? 1'b0 : (b_flag && !clr)) | ev;
            irqv = !flg;
         end
      endcase
      b_flag = flg;
      q.push_back('{cyc + 1, {irqv, flg, secev}, tag});
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr_mode(input logic [2:0] m, input string tag);
      step(1, 0, 1, m, 0, 0, 0, 0, tag);
   endtask

   task automatic to_sec(input string tag);
      while (!will_sec()) step(1, 0, 0, 3'd0, 0, 0, 0, 0, tag);
   endtask

   initial begin : watchdog
      #(CLK_P * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : drive
      rst_n = 1'b0; tick = 1'b0; sec_wr = 1'b0; mode_we = 1'b0; mode_wd = 3'd0;
      flag_clr = 1'b0; min_c = 1'b0; hour_c = 1'b0; mon_c = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset state", {irq_n, flag, sec_inc}, 3'b100);
      tick = 1'b1;
      @(negedge clk);
      check("R1 reset state with tick", {irq_n, flag, sec_inc}, 3'b100);
      rst_n = 1'b1;
      b_ph = 0; b_mode = 3'd2; b_flag = 1'b0;

      // default 2 Hz wave, first strobe after N+LAG ticks
      idle(40, "R1 R3 R4 R5 default 2Hz");
      // 1 Hz wave
      wr_mode(3'd3, "R11 R3 to 1Hz");
      idle(30, "R3 R4 1Hz");
      // clears ignored in pulse mode
      for (int i = 0; i < 6; i++) step(1, 0, 0, 3'd0, 1, 0, 0, 0, "R10 clear in 1Hz");
      wr_mode(3'd2, "R3 back to 2Hz");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 3'd0, 1, 0, 0, 0, "R10 clear in 2Hz");
      // seconds write mid-phase, with simultaneous tick
      idle(5, "R3 pre write");
      step(1, 1, 0, 3'd0, 0, 0, 0, 0, "R6 seconds write");
      idle(40, "R5 R6 after seconds write");
      // spaced timebase
      for (int i = 0; i < 40; i++) step(logic'(i % 2), 0, 0, 3'd0, 0, 0, 0, 0, "R4 spaced ticks");
      // off and forced low
      wr_mode(3'd0, "R2 off");
      for (int i = 0; i < 20; i++) step(1, logic'(i == 4), 0, 3'd0, 1, 1, 1, 1, "R2 off mode");
      wr_mode(3'd1, "R2 forced low");
      idle(20, "R2 low mode");

      // level, every second
      wr_mode(3'd4, "R11 to level second");
      to_sec("R7 wait");
      idle(1, "R7 second event");
      idle(5, "R9 hold");
      step(1, 0, 0, 3'd0, 1, 0, 0, 0, "R9 clear");
      idle(3, "R9 released");
      to_sec("R9 wait");
      step(1, 0, 0, 3'd0, 1, 0, 0, 0, "R9 event beats clear");
      idle(3, "R9 after collision");
      // mode change clears pending flag
      wr_mode(3'd5, "R11 change clears flag");
      idle(2, "R11 cleared");
      to_sec("R8 wait minute");
      step(1, 0, 0, 3'd0, 0, 0, 0, 0, "R8 minute without carry");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 3'd0, 0, 1, 1, 1, "R8 carry off event");
      to_sec("R8 wait minute");
      step(1, 0, 0, 3'd0, 0, 1, 0, 0, "R8 minute carry");
      idle(2, "R9 minute held");
      wr_mode(3'd5, "R11 same value keeps flag");
      idle(2, "R11 still held");
      // hour
      wr_mode(3'd6, "R11 to hour");
      to_sec("R8 wait hour");
      step(1, 0, 0, 3'd0, 0, 1, 0, 1, "R8 hour without carry");
      to_sec("R8 wait hour");
      step(1, 0, 0, 3'd0, 0, 0, 1, 0, "R8 hour carry");
      idle(2, "R9 hour held");
      // month
      wr_mode(3'd7, "R11 to month");
      to_sec("R8 wait month");
      step(1, 0, 0, 3'd0, 0, 1, 1, 0, "R8 month without carry");
      to_sec("R8 wait month");
      step(1, 0, 0, 3'd0, 0, 0, 0, 1, "R8 month carry");
      step(1, 1, 0, 3'd0, 0, 0, 0, 0, "R6 seconds write in level");
      idle(4, "R9 month held");
      // back to square wave
      wr_mode(3'd2, "R11 R3 return to 2Hz");
      idle(24, "R3 R4 final 2Hz");

      tick = 1'b0;
      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         n_chk++;
         n_err++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule